// File: doc/BRIEF.md
# Edge-Sensing Phase-Frequency Comparator with Lock Qualifier

This block compares two digital square waves, a reference and a feedback signal from a divided oscillator. A fast system clock samples both inputs. Only their rising edges are acted on, so the duty cycle of either signal does not change the result. The comparison drives one error output with three conditions: pull high, pull low, or released. It is modelled as a data bit plus an output enable. A downstream pad or charge pump turns that pair into a real tri-state drive.

The reference edge that comes first makes the output pull high, and the feedback edge that follows releases it. The reverse order gives a low pulse. When both edges arrive in the same sample cycle, the output stays released, so a loop built around the block settles at zero phase difference. If the reference is absent, feedback edges hold the output low, which drives the oscillator toward its minimum frequency. Because edges are matched one to one, the block does not settle on a harmonic of the reference.

A lock flag rises after a programmable number of consecutive reference periods in which no error pulse lasted longer than one sample cycle. Any longer pulse clears the flag.

Top module: `phase_freq_detector`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and on the cycle after it, `err_en`, `err_drive` and `lock` are 0.
- R2: Output encoding: `err_en`=1 with `err_drive`=1 pulls high, `err_en`=1 with `err_drive`=0 pulls low, and `err_en`=0 releases the output with `err_drive` held at 0.
- R3: From the released state, a lone rising edge on `ref_in` makes the output pull high. The change is visible three clock edges after the first edge that samples the new input level.
- R4: From the released state, a lone rising edge on `fb_in` makes the output pull low, with the same three-edge latency.
- R5: Rising edges on both inputs that reach the edge detectors in the same sample cycle leave a released output released.
- R6: While pulling high, a further `ref_in` rising edge keeps it pulling high, and a `fb_in` rising edge releases it. The low case mirrors this. The output never goes from pull-high to pull-low without passing through the released state.
- R7: Falling edges on either input have no effect on the output.
- R8: With `ref_in` held low and `fb_in` toggling, the output pulls low continuously.
- R9: `lock` rises only on a cycle that follows a detected reference rising edge. It rises once LOCK_PERIODS consecutive reference edges have been seen with no error pulse wider than one cycle.
- R10: An error pulse that lasts two or more cycles forces `lock` to 0 on the following cycle and restarts the period count.
- R11: An error pulse exactly one cycle wide does not clear `lock`.
- R12: A feedback signal at twice the reference frequency never sets `lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| err_drive | output | 1 | Error output level when enabled (1 high, 0 low) |
| err_en | output | 1 | Error output enable (0 means released) |
| lock | output | 1 | Lock qualified |

## Verification
The properties assume that each input holds a level for at least one sample period. This ensures that every rising edge reaches the detectors as one single-cycle pulse, and that the lock count sees each reference period once. The stimulus changes the inputs only at falling clock edges. It builds waveforms whose high and low phases are each a whole number of clock cycles, with random period, duty and phase offset inside those limits. Directed runs add coincident edges, a missing reference, one-cycle and three-cycle offsets, and a doubled feedback frequency.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        PH_NEUTRAL = 2'd0,
        PH_LEAD    = 2'd1,
        PH_LAG     = 2'd2
    } phase_st_e;
endpackage

// File: rtl/pfd_edge_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sh   = {sync_q.sh[TOP-1:0], din};
        sync_d.last = sync_q.sh[TOP];
        rise        = sync_q.sh[TOP] & ~sync_q.last;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end
endmodule

// File: rtl/pfd_core.sv
// Three-state phase/frequency state machine.
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic err_drive,
    output logic err_en
);
    typedef struct packed {
        phase_st_e st;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        unique case (core_q.st)
            PH_NEUTRAL: begin
                if (ref_rise && !fb_rise)      core_d.st = PH_LEAD;
                else if (fb_rise && !ref_rise) core_d.st = PH_LAG;
            end
            PH_LEAD: if (fb_rise)  core_d.st = PH_NEUTRAL;
            PH_LAG:  if (ref_rise) core_d.st = PH_NEUTRAL;
            default: core_d.st = PH_NEUTRAL;
        endcase
        err_en    = (core_q.st != PH_NEUTRAL);
        err_drive = (core_q.st == PH_LEAD);
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '{st: PH_NEUTRAL};
        else     core_q <= core_d;
    end
endmodule

// File: rtl/pfd_lock_qual.sv
// Counts clean reference periods; a pulse wider than one cycle clears the count.
module pfd_lock_qual #(
    parameter int LOCK_PERIODS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic err_en,
    input  logic ref_rise,
    output logic lock
);
    localparam int CW = $clog2(LOCK_PERIODS + 1);
    localparam logic [CW-1:0] CMAX = CW'(LOCK_PERIODS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev_en;
    } lq_t;

    lq_t lq_d, lq_q;
    logic wide;

    always_comb begin
        lq_d         = lq_q;
        wide         = err_en & lq_q.prev_en;
        lq_d.prev_en = err_en;
        if (wide)                             lq_d.cnt = '0;
        else if (ref_rise && lq_q.cnt != CMAX) lq_d.cnt = lq_q.cnt + 1'b1;
        lock = (lq_q.cnt == CMAX);
    end

    always_ff @(posedge clk) begin
        if (rst) lq_q <= '0;
        else     lq_q <= lq_d;
    end
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector #(
    parameter int SYNC_STAGES  = 2,
    parameter int LOCK_PERIODS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic err_drive,
    output logic err_en,
    output logic lock
);
    logic ref_rise, fb_rise;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .din(ref_in), .rise(ref_rise));

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst(rst), .din(fb_in), .rise(fb_rise));

    pfd_core u_core (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .err_drive(err_drive), .err_en(err_en));

    pfd_lock_qual #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
        .clk(clk), .rst(rst), .err_en(err_en), .ref_rise(ref_rise),
        .lock(lock));
endmodule

// File: rtl/phase_freq_detector_checker.sv
module phase_freq_detector_checker (
    input logic clk,
    input logic rst,
    input logic err_en,
    input logic err_drive,
    input logic lock,
    input logic ref_rise
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!err_en && !err_drive && !lock)); // R1

    AST_RELEASE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !err_en |-> !err_drive); // R2

    AST_NO_HIGH_TO_LOW: assert property (@(posedge clk) disable iff (rst)
        (err_en && err_drive) |=> !(err_en && !err_drive)); // R6

    AST_NO_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (err_en && !err_drive) |=> !(err_en && err_drive)); // R6

    AST_LOCK_ON_REF: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(ref_rise)); // R9

    AST_WIDE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (err_en && $past(err_en)) |=> !lock); // R10
endmodule

bind phase_freq_detector phase_freq_detector_checker u_chk (
    .clk(clk), .rst(rst), .err_en(err_en), .err_drive(err_drive),
    .lock(lock), .ref_rise(ref_rise));

// File: tb/phase_freq_detector_test.sv
module phase_freq_detector_test;
    localparam int LP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic err_drive, err_en, lock;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    phase_freq_detector #(.SYNC_STAGES(2), .LOCK_PERIODS(LP)) uut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .err_drive(err_drive), .err_en(err_en), .lock(lock));

    // Expected behaviour derived from R2..R11: two-flop sampling, edge on
    // 0->1 of the second flop, three-state pulse tracking, clean-period count.
    logic r1, r2, r3, f1, f2, f3, m_prev;
    int   m_st;   // 0 released, 1 pull high, 2 pull low
    int   m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            r1 = 0; r2 = 0; r3 = 0; f1 = 0; f2 = 0; f3 = 0;
            m_prev = 0; m_st = 0; m_cnt = 0;
        end else begin
            logic re, fe, en_o;
            re = r2 & ~r3;
            fe = f2 & ~f3;
            en_o = (m_st != 0);
            if (en_o && m_prev)          m_cnt = 0;
            else if (re && m_cnt != LP)  m_cnt = m_cnt + 1;
            m_prev = en_o;
            case (m_st)
                0: if (re && !fe) m_st = 1; else if (fe && !re) m_st = 2;
                1: if (fe) m_st = 0;
                default: if (re) m_st = 0;
            endcase
            r3 = r2; r2 = r1; r1 = ref_in;
            f3 = f2; f2 = f1; f1 = fb_in;
        end
    end

    function automatic logic exp_en();
        return m_st != 0;
    endfunction
    function automatic logic exp_drv();
        return m_st == 1;
    endfunction
    function automatic logic exp_lock();
        return m_cnt == LP;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the expected model.
    bit track = 0;
    always @(negedge clk) begin
        if (track && !rst) begin
            chk("R3/R4 enable", err_en, exp_en());
            chk("R2 level", err_drive, exp_drv());
            chk("R9 lock", lock, exp_lock());
        end
    end

    task automatic do_reset();
        rst = 1'b1; ref_in = 0; fb_in = 0;
        repeat (3) @(negedge clk);
        chk("R1 en in reset", err_en, 1'b0);
        chk("R1 lock in reset", lock, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 en after reset", err_en, 1'b0);
        chk("R1 drive after reset", err_drive, 1'b0);
    endtask

    task automatic waves(input int periods, input int per, input int rdut,
                         input int fper, input int fdut, input int fdel);
        for (int t = 0; t < periods * per; t++) begin
            ref_in = (t % per) < rdut;
            fb_in  = ((t + fper * 8 - fdel) % fper) < fdut;
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        track = 1;

        // R3 lone reference edge, latency of three edges
        ref_in = 1;
        repeat (2) @(negedge clk);
        chk("R3 not yet", err_en, 1'b0);
        @(negedge clk);
        chk("R3 enable", err_en, 1'b1);
        chk("R2 pull high level", err_drive, 1'b1);
        // R7 falling reference edge ignored
        ref_in = 0; repeat (4) @(negedge clk);
        chk("R7 still high", err_en && err_drive, 1'b1);
        // R6 second reference edge keeps pull high
        ref_in = 1; repeat (4) @(negedge clk);
        chk("R6 stays leading", err_en && err_drive, 1'b1);
        // R6 feedback edge releases
        fb_in = 1; repeat (3) @(negedge clk);
        chk("R6 released", err_en, 1'b0);
        chk("R2 released level", err_drive, 1'b0);

        // R4 lone feedback edge
        ref_in = 0; fb_in = 0; repeat (4) @(negedge clk);
        fb_in = 1; repeat (3) @(negedge clk);
        chk("R4 enable", err_en, 1'b1);
        chk("R4 pull low", err_drive, 1'b0);
        fb_in = 0; repeat (4) @(negedge clk);
        chk("R7 fb fall ignored", err_en, 1'b1);
        ref_in = 1; repeat (3) @(negedge clk);
        chk("R6 lag released", err_en, 1'b0);

        // R5 coincident edges
        ref_in = 0; fb_in = 0; repeat (4) @(negedge clk);
        ref_in = 1; fb_in = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R5 coincident stays released", err_en, 1'b0);
        end

        // R8 missing reference
        do_reset();
        waves(6, 8, 0, 8, 4, 0);
        chk("R8 pull low enable", err_en, 1'b1);
        chk("R8 pull low level", err_drive, 1'b0);
        chk("R8 no lock", lock, 1'b0);

        // R9 lock after clean periods
        do_reset();
        waves(6, 8, 4, 8, 4, 0);
        chk("R9 locked", lock, 1'b1);
        // R11 one-cycle pulses keep lock
        waves(4, 8, 4, 8, 4, 1);
        chk("R11 lock kept", lock, 1'b1);
        // R10 three-cycle pulses clear lock
        waves(3, 8, 4, 8, 4, 3);
        chk("R10 lock cleared", lock, 1'b0);

        // R12 feedback at twice the reference frequency
        do_reset();
        waves(12, 16, 8, 8, 4, 0);
        chk("R12 no harmonic lock", lock, 1'b0);

        // Random periods, duties and offsets (R7 duty independence)
        for (int k = 0; k < 60; k++) begin
            int per, rd, fd, dl, fp;
            per = 6 + int'($urandom_range(14));
            rd  = 1 + int'($urandom_range(per - 2));
            fd  = 1 + int'($urandom_range(per - 2));
            dl  = int'($urandom_range(per - 1));
            fp  = ($urandom_range(3) == 0) ? per + 1 : per;
            if (k % 10 == 0) dl = 0;
            waves(8, per, rd, fp, fd, dl);
        end

        track = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule